// File: doc/BRIEF.md
# Routine Instruction Pointer Sequencer

This block holds the instruction pointer of the routine that is executing in a small routine engine. A scheduler grants a routine by number. The sequencer then loads that routine's entry point from one of seven programmable start-address registers and steps through the instruction storage one instruction per clock. It advances sequentially, jumps to an address carried in the instruction, or resolves a wait-for-match instruction against a match input.

When a wait-for-match instruction sees no match, the pointer goes to one of two places. The plain form goes to the address held in the instruction. The branching form goes to one of two branch-routine addresses, picked by the received frame type, but only when that frame type is enabled in a small enable register. When an end instruction retires, the sequencer returns to idle and pulses `done` to the scheduler.

The instruction storage sits outside the block. It is read combinationally at address `ip`, and the word comes back on `instr` in the same cycle. The configuration registers are written through a one-cycle write port. A grant takes effect on any cycle, so a higher-priority routine can restart the pointer while another routine is still running.

The control machine has two states. In `ST_IDLE` a valid grant takes the transition *launch* to `ST_RUN`. In `ST_RUN` three transitions exist:
- *restart*: a valid grant arrives; the machine stays in `ST_RUN` and reloads the pointer.
- *retire*: an end instruction executes with no grant; the machine goes to `ST_IDLE` and pulses `done`.
- *step*: any other instruction executes; the machine stays in `ST_RUN`.

Top module: `rip_seq`

## Requirements
- R1: After reset `ip` is 0, `running` is 0 and `done` is 0.
- R2: A grant with `grant_valid`=1 and `grant_id` in 0..6 loads `ip` with that routine's start register at the next edge and sets `running`, whether the block was idle or running.
- R3: A grant with `grant_id`=7 is ignored. `ip`, `running` and `done` behave as if no grant were present.
- R4: Instruction word layout: bits [9:7] are the opcode and bits [6:0] are the target. Opcode 0 (sequential) loads `ip`+1, wrapping from 127 to 0.
- R5: Opcode 1 (jump) loads `ip` with the target field.
- R6: Opcode 2 (wait-for-match) loads `ip`+1 when `match_hit`=1 and loads the target field when `match_hit`=0.
- R7: Opcode 3 (wait-then-branch) loads `ip`+1 when `match_hit`=1. On a miss, `frame_type` selects branch address 0 or 1. If enable bit [`frame_type`] is set, `ip` loads that branch address. If the bit is clear, `ip` loads `ip`+1.
- R8: Opcode 4 (end) clears `running` at the next edge and raises `done` for exactly one cycle. `ip` holds its value.
- R9: Opcodes 5 to 7 behave as sequential.
- R10: A valid grant in the same cycle as any instruction, including end, takes precedence. The pointer reloads from the granted start register, and `done` stays low.
- R11: Configuration writes use `cfg_sel` values 0..6 for the start registers, 7 for branch address 0, 8 for branch address 1, and 9 for the enable bits (`cfg_data`[1:0]). A write with any other `cfg_sel` value changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | 7 | Configuration write data |
| grant_valid | input | 1 | Scheduler grants a routine this cycle |
| grant_id | input | 3 | Number of the granted routine |
| instr | input | 10 | Instruction word at `ip` |
| match_hit | input | 1 | Match result for wait instructions |
| frame_type | input | 1 | Received frame type, selects the branch address |
| ip | output | 7 | Instruction pointer |
| running | output | 1 | A routine is executing |
| done | output | 1 | One-cycle end-of-routine pulse |

## Verification
The properties assume that `instr` always holds the word stored at the current `ip`, and that `match_hit` and `frame_type` are settled before the edge on which a wait instruction resolves. The pointer-advance properties also take for granted that no grant arrives in the checked cycle; a grant overrides the instruction, so each property is guarded against it. The stimulus meets these assumptions in three ways. The bench models the storage as an array read combinationally at `ip`. It changes `match_hit`, `frame_type` and the grant only at the falling edge. It writes the configuration registers only while the block is idle.

// File: rtl/rip_pkg.sv
package rip_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SEQ    = 3'd0,
        OP_JUMP   = 3'd1,
        OP_WAIT   = 3'd2,
        OP_WAITBR = 3'd3,
        OP_END    = 3'd4
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/rip_cfg_regs.sv
module rip_cfg_regs #(
    parameter int N_ROUTINES = 7,
    parameter int ADDR_W     = 7,
    parameter int SEL_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic [ADDR_W-1:0]            data,
    output logic [N_ROUTINES*ADDR_W-1:0] start_flat,
    output logic [ADDR_W-1:0]            br_addr0,
    output logic [ADDR_W-1:0]            br_addr1,
    output logic [1:0]                   br_en
);
    localparam int SEL_BR0 = N_ROUTINES;
    localparam int SEL_BR1 = N_ROUTINES + 1;
    localparam int SEL_EN  = N_ROUTINES + 2;

    logic unused_hi;
    assign unused_hi = ^data[ADDR_W-1:2];

    // One start-address register per routine.
    for (genvar g = 0; g < N_ROUTINES; g++) begin : g_start
        logic [ADDR_W-1:0] start_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                start_q <= '0;
            else if (we && sel == SEL_W'(g))
                start_q <= data;
        end
        assign start_flat[g*ADDR_W +: ADDR_W] = start_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_addr0 <= '0;
            br_addr1 <= '0;
            br_en    <= '0;
        end else if (we) begin
            if (sel == SEL_W'(SEL_BR0)) br_addr0 <= data;
            if (sel == SEL_W'(SEL_BR1)) br_addr1 <= data;
            if (sel == SEL_W'(SEL_EN))  br_en    <= data[1:0];
        end
    end
endmodule

// File: rtl/rip_next_addr.sv
module rip_next_addr
    import rip_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int INSTR_W = ADDR_W + OP_W
) (
    input  logic [ADDR_W-1:0]  ip,
    input  logic [INSTR_W-1:0] instr,
    input  logic               match_hit,
    input  logic               frame_type,
    input  logic [ADDR_W-1:0]  br_addr0,
    input  logic [ADDR_W-1:0]  br_addr1,
    input  logic [1:0]         br_en,
    output logic [ADDR_W-1:0]  next_ip,
    output logic               is_end
);
    logic [OP_W-1:0]   op_raw;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] ip_inc;
    logic [ADDR_W-1:0] br_sel;

    assign op_raw = instr[INSTR_W-1 -: OP_W];
    assign target = instr[ADDR_W-1:0];
    assign ip_inc = ip + ADDR_W'(1);
    assign br_sel = frame_type ? br_addr1 : br_addr0;

    always_comb begin
        next_ip = ip_inc;
        is_end  = 1'b0;
        case (op_raw)
            OP_JUMP:   next_ip = target;
            OP_WAIT:   next_ip = match_hit ? ip_inc : target;
            OP_WAITBR: begin
                if (!match_hit && br_en[frame_type])
                    next_ip = br_sel;
            end
            OP_END: begin
                next_ip = ip;
                is_end  = 1'b1;
            end
            default:   next_ip = ip_inc;
        endcase
    end
endmodule

// File: rtl/rip_fsm.sv
module rip_fsm
    import rip_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_ok,
    input  logic [ADDR_W-1:0] grant_addr,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic              is_end,
    output logic [ADDR_W-1:0] ip,
    output logic              running,
    output logic              done
);
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] ip_q, ip_d;
    logic              done_q, done_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ip_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ip_q    <= ip_d;
            done_q  <= done_d;
        end
    end

    // Transitions: launch, restart, step, retire.
    always_comb begin
        state_d = state_q;
        ip_d    = ip_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_ok) begin
                    state_d = ST_RUN;
                    ip_d    = grant_addr;
                end
            end
            ST_RUN: begin
                if (grant_ok) begin
                    ip_d = grant_addr;
                end else if (is_end) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    ip_d = next_ip;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        ip      = ip_q;
        running = (state_q == ST_RUN);
        done    = done_q;
    end
endmodule

// File: rtl/rip_seq.sv
module rip_seq
    import rip_pkg::*;
#(
    parameter int N_ROUTINES = 7,
    parameter int ADDR_W     = 7,
    parameter int SEL_W      = 4,
    parameter int ID_W       = $clog2(N_ROUTINES + 1),
    parameter int INSTR_W    = ADDR_W + OP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_data,
    input  logic               grant_valid,
    input  logic [ID_W-1:0]    grant_id,
    input  logic [INSTR_W-1:0] instr,
    input  logic               match_hit,
    input  logic               frame_type,
    output logic [ADDR_W-1:0]  ip,
    output logic               running,
    output logic               done
);
    logic [N_ROUTINES*ADDR_W-1:0] start_flat;
    logic [ADDR_W-1:0]            br_addr0, br_addr1;
    logic [1:0]                   br_en;
    logic [ADDR_W-1:0]            next_ip;
    logic                         is_end;
    logic                         grant_ok;
    logic [ADDR_W-1:0]            grant_addr;

    rip_cfg_regs #(.N_ROUTINES(N_ROUTINES), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .data       (cfg_data),
        .start_flat (start_flat),
        .br_addr0   (br_addr0),
        .br_addr1   (br_addr1),
        .br_en      (br_en)
    );

    assign grant_ok = grant_valid && (grant_id < ID_W'(N_ROUTINES));

    always_comb begin
        grant_addr = '0;
        for (int i = 0; i < N_ROUTINES; i++)
            if (grant_id == ID_W'(i))
                grant_addr = start_flat[i*ADDR_W +: ADDR_W];
    end

    rip_next_addr #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) nxt_i (
        .ip         (ip),
        .instr      (instr),
        .match_hit  (match_hit),
        .frame_type (frame_type),
        .br_addr0   (br_addr0),
        .br_addr1   (br_addr1),
        .br_en      (br_en),
        .next_ip    (next_ip),
        .is_end     (is_end)
    );

    rip_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_ok   (grant_ok),
        .grant_addr (grant_addr),
        .next_ip    (next_ip),
        .is_end     (is_end),
        .ip         (ip),
        .running    (running),
        .done       (done)
    );
endmodule

// File: rtl/rip_seq_chk.sv
module rip_seq_chk #(
    parameter int ADDR_W  = 7,
    parameter int ID_W    = 3,
    parameter int INSTR_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               grant_valid,
    input logic [ID_W-1:0]    grant_id,
    input logic [INSTR_W-1:0] instr,
    input logic               match_hit,
    input logic [ADDR_W-1:0]  ip,
    input logic               running,
    input logic               done
);
    logic       gnt;
    logic [2:0] op;
    assign gnt = grant_valid && (grant_id != '1);
    assign op  = instr[INSTR_W-1 -: 3];

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && !gnt && op == 3'd4 |=> done && !running && $stable(ip));

    // R2
    grant_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> running && !done);

    // R3
    bad_grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !gnt |=> !running && $stable(ip));

    // R5
    jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && !gnt && op == 3'd1 |=> ip == $past(instr[ADDR_W-1:0]));

    // R6
    wait_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && !gnt && op == 3'd2 && match_hit |=> ip == ADDR_W'($past(ip) + ADDR_W'(1)));

    // R6
    wait_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && !gnt && op == 3'd2 && !match_hit |=> ip == $past(instr[ADDR_W-1:0]));
endmodule

bind rip_seq rip_seq_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .INSTR_W(INSTR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .instr       (instr),
    .match_hit   (match_hit),
    .ip          (ip),
    .running     (running),
    .done        (done)
);

// File: tb/rip_seq_tb_top.sv
module rip_seq_tb_top;
    localparam int CLK_P = 10;

    typedef struct {
        logic [6:0] ip;
        logic       run;
        logic       dn;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [6:0] cfg_data = '0;
    logic       grant_valid = 1'b0;
    logic [2:0] grant_id = '0;
    logic [9:0] instr;
    logic       match_hit = 1'b0;
    logic       frame_type = 1'b0;
    logic [6:0] ip;
    logic       running, done;

    logic [9:0] imem [128];
    assign instr = imem[ip];

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;
    logic [6:0] cur_ip = '0;
    logic       cur_run = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rip_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .grant_valid(grant_valid), .grant_id(grant_id),
        .instr(instr), .match_hit(match_hit), .frame_type(frame_type),
        .ip(ip), .running(running), .done(done)
    );

    task automatic push(input logic [6:0] e_ip, input logic e_run, input logic e_dn,
                        input string tag);
        exp_t e;
        e.ip = e_ip; e.run = e_run; e.dn = e_dn; e.tag = tag;
        exp_q.push_back(e);
        cur_ip = e_ip;
        cur_run = e_run;
    endtask

    task automatic step(input logic gv, input logic [2:0] gid, input logic m,
                        input logic ft, input logic [6:0] e_ip, input logic e_run,
                        input logic e_dn, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        grant_valid = gv; grant_id = gid; match_hit = m; frame_type = ft;
        push(e_ip, e_run, e_dn, tag);
    endtask

    task automatic cfgw(input logic [3:0] sel, input logic [6:0] data, input string tag);
        @(negedge clk);
        grant_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        push(cur_ip, cur_run, 1'b0, tag);
    endtask

    // Monitor: compares each expected item after the edge it belongs to.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (ip !== e.ip || running !== e.run || done !== e.dn) begin
                    n_err++;
                    $display("FAIL %s: ip=%0d running=%0b done=%0b, expected ip=%0d running=%0b done=%0b",
                             e.tag, ip, running, done, e.ip, e.run, e.dn);
                end
            end
        end
    end

    // Driver.
    initial begin
        for (int i = 0; i < 128; i++) imem[i] = {3'd4, 7'd0};
        imem[50]  = {3'd0, 7'd0};
        imem[51]  = {3'd1, 7'd60};
        imem[60]  = {3'd2, 7'd70};
        imem[70]  = {3'd2, 7'd90};
        imem[71]  = {3'd5, 7'd0};
        imem[72]  = {3'd3, 7'd0};
        imem[112] = {3'd3, 7'd0};
        imem[113] = {3'd3, 7'd0};
        imem[98]  = {3'd0, 7'd0};
        imem[99]  = {3'd0, 7'd0};
        imem[66]  = {3'd3, 7'd0};
        imem[82]  = {3'd1, 7'd127};
        imem[127] = {3'd0, 7'd0};

        step(0, 0, 0, 0, 7'd0, 0, 0, "R1 reset");
        step(0, 0, 0, 0, 7'd0, 0, 0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 7; i++) cfgw(4'(i), 7'(16*i + 2), "R11 start write");
        cfgw(4'd7, 7'h70, "R11 branch0 write");
        cfgw(4'd8, 7'h78, "R11 branch1 write");
        cfgw(4'd9, 7'd1,  "R11 enable write");

        step(1, 3, 0, 0, 7'd50, 1, 0, "R2 grant routine 3");
        step(0, 0, 0, 0, 7'd51, 1, 0, "R4 sequential");
        step(0, 0, 0, 0, 7'd60, 1, 0, "R5 jump");
        step(0, 0, 0, 0, 7'd70, 1, 0, "R6 wait miss");
        step(0, 0, 1, 0, 7'd71, 1, 0, "R6 wait hit");
        step(0, 0, 0, 0, 7'd72, 1, 0, "R9 unused opcode");
        step(0, 0, 0, 0, 7'd112, 1, 0, "R7 branch miss enabled type0");
        step(0, 0, 0, 1, 7'd113, 1, 0, "R7 branch miss disabled type1");
        step(0, 0, 1, 0, 7'd114, 1, 0, "R7 branch hit");
        step(0, 0, 0, 0, 7'd114, 0, 1, "R8 end retires");
        step(0, 0, 0, 0, 7'd114, 0, 0, "R8 done one cycle");
        step(1, 7, 0, 0, 7'd114, 0, 0, "R3 invalid grant ignored");
        step(1, 6, 0, 0, 7'd98, 1, 0, "R2 grant routine 6");
        step(0, 0, 0, 0, 7'd99, 1, 0, "R4 sequential");
        step(1, 1, 0, 0, 7'd18, 1, 0, "R2 R10 restart while running");
        step(1, 0, 0, 0, 7'd2, 1, 0, "R10 grant beats end");
        step(0, 0, 0, 0, 7'd2, 0, 1, "R8 end retires");
        cfgw(4'd9, 7'd3, "R11 enable write");
        cfgw(4'd12, 7'h55, "R11 unmapped write");
        step(1, 0, 0, 0, 7'd2, 1, 0, "R11 start0 unchanged");
        step(0, 0, 0, 0, 7'd2, 0, 1, "R8 end retires");
        step(1, 4, 0, 0, 7'd66, 1, 0, "R2 grant routine 4");
        step(0, 0, 0, 1, 7'd120, 1, 0, "R7 branch miss enabled type1");
        step(0, 0, 0, 0, 7'd120, 0, 1, "R8 end retires");
        step(1, 5, 0, 0, 7'd82, 1, 0, "R2 grant routine 5");
        step(0, 0, 0, 0, 7'd127, 1, 0, "R5 jump to top");
        step(0, 0, 0, 0, 7'd0, 1, 0, "R4 wrap to zero");
        step(0, 0, 0, 0, 7'd0, 0, 1, "R8 end retires");
        @(negedge clk);
        grant_valid = 1'b0;
        @(posedge clk);
        #(CLK_P/2);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule